// File: doc/BRIEF.md
# Acquisition Start and FIFO Status Controller

This block decides when a sampling run may begin and reports the state of the sample FIFO and the interrupt sources to a host. The host writes to a small set of register addresses. One holds the trigger setup. A write to another starts a run in software. A third clears the FIFO and the start logic. A fourth holds the interrupt and DMA setup. A fifth acknowledges a DMA terminal count. The host reads back a single status word.

A run can begin in three ways: at once on a software start, after a settling hold of a fixed number of sample periods, or on the first rising edge of an external trigger once that trigger has been armed. The settling hold lets the filters ahead of the FIFO settle after the sample clock changes. The FIFO storage and the DMA engine sit outside the block and are seen only through flag and pulse inputs. Converter samples arrive in offset binary and leave in two's complement, so the host restores offset binary by inverting the top bit.

Top module: `acq_trig_ctrl`

## Requirements
- R1: A write to address 0 stores the trigger setup. A field value of 3 in bits [1:0] selects the settling-hold mode, and any other value (2 is the usual one) selects immediate start. Bit 4 arms the external trigger. If bit 4 is clear, a write to address 1 while idle starts the run in immediate mode, and `acq_active` is high after that write's clock edge.
- R2: In settling-hold mode a start puts the block into a hold. `acq_active` rises at the clock edge that accepts the DELAY_TICKS-th `sample_tick` pulse (72 by default) and stays low before that edge.
- R3: A write to address 0 with bit 4 set arms the external trigger, and a write to address 1 while armed is ignored. With the default two synchroniser stages, the run starts on the third rising clock edge after `ext_trig` is first seen high.
- R4: While a run is active, further trigger edges and start writes have no effect. An `acq_done` pulse ends the run and sets status bit 4 (end of acquisition).
- R5: A write to address 2 returns the start logic to idle, drives `fifo_clear` high for exactly the one cycle after the write edge, and clears status bits 3 and 4.
- R6: Status bit 3 (overflow) is set by a `fifo_overflow` pulse and is sticky. Only a write to address 2 clears it, and that write wins over a pulse in the same cycle.
- R7: Status bit 7 (terminal count) is set by a `dma_tc` pulse and cleared by any write to address 4. A pulse in the same cycle as that write leaves the bit set.
- R8: A write to address 3 sets the outputs from these fields: [2:0] DMA channel, bit 3 DMA enable, [7:4] interrupt level, bit 8 FIFO interrupt enable, bit 9 half-full interrupt option, bit 11 terminal-count interrupt enable, bit 12 demand-mode DMA.
- R9: `irq` and status bit 6 both equal (bit8 AND (end-of-acquisition OR (bit9 AND `fifo_half_full`))) OR (bit11 AND terminal-count flag).
- R10: Status bit 5 (calibration busy) goes high on the clock edge at which `dig_pd` is first sampled low after being high, and stays high for exactly CAL_CYCLES cycles.
- R11: Status bit 0 follows `fifo_not_empty`. Bits [9:8] hold BOARD_ID. Bits 1, 2 and [15:10] read 0.
- R12: `sample_out` equals `sample_in` with its most significant bit inverted.
- R13: After reset the start logic is idle, every flag is 0 and every interrupt and DMA setting is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_addr | input | 3 | Register address of the write |
| host_wdata | input | 16 | Write data |
| ext_trig | input | 1 | External start trigger, asynchronous |
| sample_tick | input | 1 | One pulse per sample period |
| acq_done | input | 1 | Pulse marking the last sample of a run |
| fifo_not_empty | input | 1 | FIFO holds data |
| fifo_half_full | input | 1 | FIFO at least half full |
| fifo_overflow | input | 1 | Pulse on a write into a full FIFO |
| dma_tc | input | 1 | Pulse on DMA terminal count |
| dig_pd | input | 1 | Digital power-down level |
| sample_in | input | DATA_W | Converter sample, offset binary |
| acq_active | output | 1 | Samples are admitted to the FIFO |
| fifo_clear | output | 1 | One-cycle FIFO clear pulse |
| status_word | output | 16 | Host status word |
| irq | output | 1 | Interrupt request |
| dma_chan | output | 3 | DMA channel setting |
| dma_en | output | 1 | DMA enable |
| dma_demand | output | 1 | Demand-mode DMA |
| irq_level | output | 4 | Interrupt level setting |
| sample_out | output | DATA_W | Sample in two's complement |

## Verification
Register writes take effect one clock edge after the cycle in which they are presented. Flags follow their input pulses at the next edge. `irq` and status bit 0 respond to their level inputs within the same cycle. An external trigger edge reaches `acq_active` after three edges, and the settling hold ends on the edge of the last counted tick. Inputs change on falling edges, and every result is sampled on the falling edge after the rising edge at which it is due. The hold and calibration windows are measured by counting those falling edges. Random pulses and writes are scored against a flag model in the bench that is advanced once per cycle.

// File: rtl/acq_trig_pkg.sv
package acq_trig_pkg;

   localparam int REG_W = 16;

   // host register addresses
   localparam logic [2:0] A_TRIG     = 3'd0;
   localparam logic [2:0] A_START    = 3'd1;
   localparam logic [2:0] A_FIFO_RST = 3'd2;
   localparam logic [2:0] A_IRQDMA   = 3'd3;
   localparam logic [2:0] A_TC_CLR   = 3'd4;

   // status word bit positions
   localparam int S_NE   = 0;
   localparam int S_OVF  = 3;
   localparam int S_EOA  = 4;
   localparam int S_CAL  = 5;
   localparam int S_PEND = 6;
   localparam int S_TC   = 7;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ARMED,
      ST_DELAY,
      ST_RUN
   } acq_state_e;

   typedef struct packed {
      logic       demand;
      logic       tc_ie;
      logic       hf_sel;
      logic       fifo_ie;
      logic [3:0] irq_lvl;
      logic       dma_en;
      logic [2:0] chan;
   } irqdma_cfg_t;

endpackage

// File: rtl/acq_trig_fsm.sv
module acq_trig_fsm
   import acq_trig_pkg::*;
#(
   parameter int DELAY_TICKS     = 72,
   parameter int EXT_SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cfg_wr,
   input  logic cfg_delay,
   input  logic cfg_hw_en,
   input  logic start_wr,
   input  logic clr,
   input  logic ext_trig,
   input  logic sample_tick,
   input  logic acq_done,
   output logic active,
   output logic eoa_set
);

   localparam int CW = (DELAY_TICKS > 1) ? $clog2(DELAY_TICKS) : 1;
   localparam logic [CW-1:0] LAST = CW'(DELAY_TICKS - 1);

   if (DELAY_TICKS < 2) begin : g_bad_delay
      $error("DELAY_TICKS must be at least 2");
   end
   if (EXT_SYNC_STAGES == 1 || EXT_SYNC_STAGES < 0) begin : g_bad_sync
      $error("EXT_SYNC_STAGES must be 0 or at least 2");
   end

   logic ext_s, ext_prev, rise;

   if (EXT_SYNC_STAGES == 0) begin : g_nosync
      assign ext_s = ext_trig;
   end else begin : g_sync
      logic [EXT_SYNC_STAGES-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh <= '0;
         else        sh <= {sh[EXT_SYNC_STAGES-2:0], ext_trig};
      end
      assign ext_s = sh[EXT_SYNC_STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ext_prev <= 1'b0;
      else        ext_prev <= ext_s;
   end
   assign rise = ext_s & ~ext_prev;

   acq_state_e    state_q, state_d;
   logic [CW-1:0] cnt_q, cnt_d;
   logic          delay_q, hw_q;

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      unique case (state_q)
         ST_IDLE: begin
            if (cfg_wr) begin
               state_d = cfg_hw_en ? ST_ARMED : ST_IDLE;
            end else if (start_wr && !hw_q) begin
               state_d = delay_q ? ST_DELAY : ST_RUN;
               cnt_d   = '0;
            end
         end
         ST_ARMED: begin
            if (cfg_wr && !cfg_hw_en) begin
               state_d = ST_IDLE;
            end else if (rise) begin
               state_d = delay_q ? ST_DELAY : ST_RUN;
               cnt_d   = '0;
            end
         end
         ST_DELAY: begin
            if (sample_tick) begin
               if (cnt_q == LAST) state_d = ST_RUN;
               else               cnt_d   = cnt_q + 1'b1;
            end
         end
         ST_RUN: begin
            if (acq_done) state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
      if (clr) state_d = ST_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         delay_q <= 1'b0;
         hw_q    <= 1'b0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         if (cfg_wr) begin
            delay_q <= cfg_delay;
            hw_q    <= cfg_hw_en;
         end
      end
   end

   assign active  = (state_q == ST_RUN);
   assign eoa_set = (state_q == ST_RUN) && acq_done && !clr;

   // R5
   clr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (state_q == ST_IDLE));

   // R4
   run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN && !acq_done && !clr) |=> (state_q == ST_RUN));

   // R2
   delay_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DELAY && !sample_tick && !clr) |=> (state_q == ST_DELAY));

endmodule

// File: rtl/acq_cal_timer.sv
module acq_cal_timer #(
   parameter int CAL_CYCLES = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dig_pd,
   output logic busy
);

   localparam int W = $clog2(CAL_CYCLES + 1);
   localparam logic [W-1:0] LOAD = W'(CAL_CYCLES);

   if (CAL_CYCLES < 1) begin : g_bad_cal
      $error("CAL_CYCLES must be at least 1");
   end

   logic         pd_q;
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pd_q  <= 1'b0;
         cnt_q <= '0;
      end else begin
         pd_q <= dig_pd;
         if (dig_pd)          cnt_q <= '0;
         else if (pd_q)       cnt_q <= LOAD;
         else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
      end
   end

   assign busy = (cnt_q != '0);

   // R10
   cal_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_q && !dig_pd) |=> busy);

endmodule

// File: rtl/acq_irq_status.sv
module acq_irq_status
   import acq_trig_pkg::*;
#(
   parameter int BOARD_ID = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              tc_clr,
   input  logic              cfg_wr,
   input  irqdma_cfg_t       cfg_in,
   input  logic              fifo_ne,
   input  logic              fifo_hf,
   input  logic              fifo_ovf,
   input  logic              dma_tc,
   input  logic              eoa_set,
   input  logic              cal_busy,
   output irqdma_cfg_t       cfg_q,
   output logic [REG_W-1:0]  status,
   output logic              irq
);

   if (BOARD_ID < 0 || BOARD_ID > 3) begin : g_bad_id
      $error("BOARD_ID must fit in two bits");
   end
   localparam logic [1:0] ID_BITS = 2'(BOARD_ID);

   logic ovf_q, eoa_q, tc_q, pend;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
         ovf_q <= 1'b0;
         eoa_q <= 1'b0;
         tc_q  <= 1'b0;
      end else begin
         if (cfg_wr) cfg_q <= cfg_in;
         if (clr)           ovf_q <= 1'b0;
         else if (fifo_ovf) ovf_q <= 1'b1;
         if (clr)          eoa_q <= 1'b0;
         else if (eoa_set) eoa_q <= 1'b1;
         if (dma_tc)      tc_q <= 1'b1;
         else if (tc_clr) tc_q <= 1'b0;
      end
   end

   assign pend = (cfg_q.fifo_ie & (eoa_q | (cfg_q.hf_sel & fifo_hf)))
               | (cfg_q.tc_ie & tc_q);
   assign irq  = pend;

   always_comb begin
      status         = '0;
      status[S_NE]   = fifo_ne;
      status[S_OVF]  = ovf_q;
      status[S_EOA]  = eoa_q;
      status[S_CAL]  = cal_busy;
      status[S_PEND] = pend;
      status[S_TC]   = tc_q;
      status[9:8]    = ID_BITS;
   end

   // R6
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_q && !clr) |=> ovf_q);

   // R7
   tc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dma_tc |=> tc_q);

   // R9
   irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (cfg_q.fifo_ie || cfg_q.tc_ie));

endmodule

// File: rtl/acq_trig_ctrl.sv
module acq_trig_ctrl
   import acq_trig_pkg::*;
#(
   parameter int DATA_W          = 16,
   parameter int DELAY_TICKS     = 72,
   parameter int EXT_SYNC_STAGES = 2,
   parameter int CAL_CYCLES      = 64,
   parameter int BOARD_ID        = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic [2:0]        host_addr,
   input  logic [15:0]       host_wdata,
   input  logic              ext_trig,
   input  logic              sample_tick,
   input  logic              acq_done,
   input  logic              fifo_not_empty,
   input  logic              fifo_half_full,
   input  logic              fifo_overflow,
   input  logic              dma_tc,
   input  logic              dig_pd,
   input  logic [DATA_W-1:0] sample_in,
   output logic              acq_active,
   output logic              fifo_clear,
   output logic [15:0]       status_word,
   output logic              irq,
   output logic [2:0]        dma_chan,
   output logic              dma_en,
   output logic              dma_demand,
   output logic [3:0]        irq_level,
   output logic [DATA_W-1:0] sample_out
);

   if (DATA_W < 2) begin : g_bad_w
      $error("DATA_W must be at least 2");
   end

   logic wr_trig, wr_start, wr_rst, wr_cfg, wr_tc;
   assign wr_trig  = host_wr && (host_addr == A_TRIG);
   assign wr_start = host_wr && (host_addr == A_START);
   assign wr_rst   = host_wr && (host_addr == A_FIFO_RST);
   assign wr_cfg   = host_wr && (host_addr == A_IRQDMA);
   assign wr_tc    = host_wr && (host_addr == A_TC_CLR);

   logic unused_wdata;
   assign unused_wdata = ^{host_wdata[15:13], host_wdata[10]};

   irqdma_cfg_t cfg_new, cfg_q;
   always_comb begin
      cfg_new.chan    = host_wdata[2:0];
      cfg_new.dma_en  = host_wdata[3];
      cfg_new.irq_lvl = host_wdata[7:4];
      cfg_new.fifo_ie = host_wdata[8];
      cfg_new.hf_sel  = host_wdata[9];
      cfg_new.tc_ie   = host_wdata[11];
      cfg_new.demand  = host_wdata[12];
   end

   logic eoa_set, cal_busy;

   acq_trig_fsm #(
      .DELAY_TICKS     (DELAY_TICKS),
      .EXT_SYNC_STAGES (EXT_SYNC_STAGES)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_wr      (wr_trig),
      .cfg_delay   (host_wdata[1:0] == 2'b11),
      .cfg_hw_en   (host_wdata[4]),
      .start_wr    (wr_start),
      .clr         (wr_rst),
      .ext_trig    (ext_trig),
      .sample_tick (sample_tick),
      .acq_done    (acq_done),
      .active      (acq_active),
      .eoa_set     (eoa_set)
   );

   acq_cal_timer #(
      .CAL_CYCLES (CAL_CYCLES)
   ) u_cal (
      .clk    (clk),
      .rst_n  (rst_n),
      .dig_pd (dig_pd),
      .busy   (cal_busy)
   );

   acq_irq_status #(
      .BOARD_ID (BOARD_ID)
   ) u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (wr_rst),
      .tc_clr   (wr_tc),
      .cfg_wr   (wr_cfg),
      .cfg_in   (cfg_new),
      .fifo_ne  (fifo_not_empty),
      .fifo_hf  (fifo_half_full),
      .fifo_ovf (fifo_overflow),
      .dma_tc   (dma_tc),
      .eoa_set  (eoa_set),
      .cal_busy (cal_busy),
      .cfg_q    (cfg_q),
      .status   (status_word),
      .irq      (irq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fifo_clear <= 1'b0;
      else        fifo_clear <= wr_rst;
   end

   assign dma_chan   = cfg_q.chan;
   assign dma_en     = cfg_q.dma_en;
   assign dma_demand = cfg_q.demand;
   assign irq_level  = cfg_q.irq_lvl;

   assign sample_out = {~sample_in[DATA_W-1], sample_in[DATA_W-2:0]};

   // R5
   clear_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_clear |-> !$past(fifo_clear) || $past(wr_rst));

endmodule

// File: tb/tb_acq_trig_ctrl.sv
`timescale 1ns/1ps
module tb_acq_trig_ctrl;

   localparam int DT  = 72;
   localparam int CAL = 64;
   localparam int BID = 0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0;
   logic [2:0]  host_addr = '0;
   logic [15:0] host_wdata = '0;
   logic        ext_trig = 1'b0, sample_tick = 1'b0, acq_done = 1'b0;
   logic        fifo_not_empty = 1'b0, fifo_half_full = 1'b0;
   logic        fifo_overflow = 1'b0, dma_tc = 1'b0, dig_pd = 1'b1;
   logic [15:0] sample_in = '0;
   logic        acq_active, fifo_clear, irq, dma_en, dma_demand;
   logic [15:0] status_word, sample_out;
   logic [2:0]  dma_chan;
   logic [3:0]  irq_level;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   acq_trig_ctrl dut (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
      .host_wdata(host_wdata), .ext_trig(ext_trig), .sample_tick(sample_tick),
      .acq_done(acq_done), .fifo_not_empty(fifo_not_empty),
      .fifo_half_full(fifo_half_full), .fifo_overflow(fifo_overflow),
      .dma_tc(dma_tc), .dig_pd(dig_pd), .sample_in(sample_in),
      .acq_active(acq_active), .fifo_clear(fifo_clear),
      .status_word(status_word), .irq(irq), .dma_chan(dma_chan),
      .dma_en(dma_en), .dma_demand(dma_demand), .irq_level(irq_level),
      .sample_out(sample_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_status(input logic ne, input logic ovf,
         input logic eoa, input logic cal, input logic pend, input logic tc);
      logic [15:0] s;
      s = '0;
      s[0] = ne; s[3] = ovf; s[4] = eoa; s[5] = cal; s[6] = pend; s[7] = tc;
      s[9:8] = 2'(BID);
      return s;
   endfunction

   function automatic logic exp_irq(input logic fie, input logic hfs, input logic tcie,
         input logic eoa, input logic hf, input logic tc);
      return (fie & (eoa | (hfs & hf))) | (tcie & tc);
   endfunction

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic tick();
      @(negedge clk); sample_tick = 1'b1;
      @(negedge clk); sample_tick = 1'b0;
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_up();
   end

   initial begin
      logic ovf_m, eoa_m, tc_m, fie_m, hfs_m, tcie_m, clr_m;
      int cal_n;
      void'($urandom(32'd20411));
      repeat (3) @(negedge clk);
      // R13 R11 reset state
      chk("R13 status", status_word, exp_status(0, 0, 0, 0, 0, 0));
      chk("R13 active", acq_active, 0);
      chk("R13 irq", irq, 0);
      chk("R13 dma", {dma_chan, dma_en, dma_demand, irq_level}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R13 after release", {acq_active, fifo_clear, status_word}, {2'b00, exp_status(0, 0, 0, 0, 0, 0)});

      // R12
      sample_in = 16'h1234; #1 chk("R12 convert", sample_out, 16'h9234);
      sample_in = 16'h8000; #1 chk("R12 midscale", sample_out, 16'h0000);
      sample_in = 16'h7FFF; #1 chk("R12 low", sample_out, 16'hFFFF);

      // R11
      fifo_not_empty = 1'b1; #1 chk("R11 not empty", status_word, exp_status(1, 0, 0, 0, 0, 0));
      fifo_not_empty = 1'b0;

      // R1 immediate start
      wr(3'd0, 16'h0002);
      chk("R1 config alone no start", acq_active, 0);
      wr(3'd1, 16'h0000);
      chk("R1 immediate start", acq_active, 1);
      // R4 further starts and trigger edges ignored
      wr(3'd1, 16'h0000);
      ext_trig = 1'b1; repeat (4) @(negedge clk); ext_trig = 1'b0; repeat (4) @(negedge clk);
      chk("R4 still active", acq_active, 1);
      acq_done = 1'b1; @(negedge clk); acq_done = 1'b0;
      chk("R4 done ends run", acq_active, 0);
      chk("R4 eoa flag", status_word, exp_status(0, 0, 1, 0, 0, 0));

      // R5 fifo reset
      wr(3'd2, 16'h0000);
      chk("R5 clear pulse", fifo_clear, 1);
      chk("R5 eoa cleared", status_word, exp_status(0, 0, 0, 0, 0, 0));
      @(negedge clk);
      chk("R5 clear pulse one cycle", fifo_clear, 0);

      // R2 settling hold
      wr(3'd0, 16'h0003);
      wr(3'd1, 16'h0000);
      chk("R2 hold after start", acq_active, 0);
      for (int i = 0; i < DT - 1; i++) tick();
      repeat (3) @(negedge clk);
      chk("R2 inactive before last tick", acq_active, 0);
      tick();
      chk("R2 active at last tick", acq_active, 1);
      wr(3'd2, 16'h0000);
      chk("R5 run stopped by reset", acq_active, 0);

      // R3 external trigger
      wr(3'd0, 16'h0012);
      wr(3'd1, 16'h0000);
      chk("R3 soft start ignored when armed", acq_active, 0);
      @(negedge clk); ext_trig = 1'b1;
      @(negedge clk); @(negedge clk);
      chk("R3 not yet after two edges", acq_active, 0);
      @(negedge clk);
      chk("R3 active on third edge", acq_active, 1);
      ext_trig = 1'b0; repeat (3) @(negedge clk);
      ext_trig = 1'b1; repeat (3) @(negedge clk); ext_trig = 1'b0;
      wr(3'd1, 16'h0000);
      chk("R4 second edge ignored", acq_active, 1);
      wr(3'd2, 16'h0000);
      chk("R5 reset from armed run", acq_active, 0);

      // R10 calibration
      @(negedge clk); dig_pd = 1'b0;
      @(negedge clk);
      chk("R10 busy set", status_word[5], 1);
      cal_n = 0;
      for (int k = 0; k < CAL + 10; k++) begin
         if (status_word[5]) begin cal_n++; @(negedge clk); end
      end
      chk("R10 busy length", cal_n, CAL);
      chk("R10 busy cleared", status_word[5], 0);

      // R8 control fields
      wr(3'd3, 16'h19AD);
      chk("R8 dma chan", dma_chan, 3'd5);
      chk("R8 dma enable", dma_en, 1);
      chk("R8 irq level", irq_level, 4'hA);
      chk("R8 demand", dma_demand, 1);
      chk("R9 no source irq low", irq, 0);

      // R7 terminal count
      @(negedge clk); dma_tc = 1'b1; @(negedge clk); dma_tc = 1'b0;
      chk("R7 tc set", status_word, exp_status(0, 0, 0, 0, 1, 1));
      chk("R9 tc irq", irq, 1);
      wr(3'd4, 16'h0000);
      chk("R7 tc cleared", status_word[7], 0);
      chk("R9 irq dropped", irq, 0);
      @(negedge clk); dma_tc = 1'b1; host_wr = 1'b1; host_addr = 3'd4;
      @(negedge clk); dma_tc = 1'b0; host_wr = 1'b0;
      chk("R7 set wins over clear", status_word[7], 1);
      wr(3'd4, 16'h0000);

      // R6 overflow
      @(negedge clk); fifo_overflow = 1'b1; @(negedge clk); fifo_overflow = 1'b0;
      chk("R6 overflow set", status_word[3], 1);
      wr(3'd4, 16'h0000);
      wr(3'd1, 16'h0000);
      chk("R6 overflow sticky", status_word[3], 1);
      wr(3'd2, 16'h0000);
      chk("R6 overflow reset", status_word[3], 0);
      @(negedge clk); fifo_overflow = 1'b1; host_wr = 1'b1; host_addr = 3'd2;
      @(negedge clk); fifo_overflow = 1'b0; host_wr = 1'b0;
      chk("R6 reset wins", status_word[3], 0);

      // R9 half-full option
      wr(3'd3, 16'h0300);
      fifo_half_full = 1'b1; #1 chk("R9 half full irq", irq, 1);
      wr(3'd3, 16'h0100);
      chk("R9 half full masked", irq, 0);
      fifo_half_full = 1'b0;

      // random phase: R6 R7 R9 R11
      wr(3'd3, 16'h0000);
      wr(3'd2, 16'h0000);
      wr(3'd4, 16'h0000);
      ovf_m = 0; eoa_m = 0; tc_m = 0; fie_m = 0; hfs_m = 0; tcie_m = 0; clr_m = 0;
      for (int it = 0; it < 400; it++) begin
         int op;
         logic [15:0] d;
         @(negedge clk);
         chk("R6 R7 R9 R11 random status", status_word,
             exp_status(fifo_not_empty, ovf_m, eoa_m, 0,
                exp_irq(fie_m, hfs_m, tcie_m, eoa_m, fifo_half_full, tc_m), tc_m));
         chk("R9 random irq", irq, exp_irq(fie_m, hfs_m, tcie_m, eoa_m, fifo_half_full, tc_m));
         chk("R5 random clear pulse", fifo_clear, clr_m);
         fifo_overflow  = ($urandom % 8) == 0;
         dma_tc         = ($urandom % 5) == 0;
         fifo_half_full = $urandom % 2;
         fifo_not_empty = $urandom % 2;
         op = $urandom % 10;
         d  = 16'($urandom);
         host_wr = (op <= 2);
         host_addr = (op == 0) ? 3'd2 : (op == 1) ? 3'd4 : 3'd3;
         host_wdata = d;
         clr_m = (op == 0);
         ovf_m = (op == 0) ? 1'b0 : (ovf_m | fifo_overflow);
         if (op == 0) eoa_m = 1'b0;
         tc_m  = dma_tc ? 1'b1 : ((op == 1) ? 1'b0 : tc_m);
         if (op == 2) begin fie_m = d[8]; hfs_m = d[9]; tcie_m = d[11]; end
      end
      @(negedge clk);
      host_wr = 1'b0; fifo_overflow = 1'b0; dma_tc = 1'b0;
      @(negedge clk);
      finish_up();
   end

endmodule